// File: doc/BRIEF.md
# Word Clock Rate Detector and Resynchroniser

This block works out the oversampling factor n by measuring the received word clock against the system clock. It then rebuilds the sample timing from the system clock alone. An internal cycle is either every `clk_in` cycle or every second one, as set by `div_sel`. The block counts internal cycles between rising word clock edges. A period that is an exact multiple of eight gives a candidate factor n = period / 8, valid from 3 to 24. When two consecutive periods give the same candidate, the block raises `locked` and reports the factor.

While locked, a counter of 8·n internal cycles runs on its own. It produces the sample-load strobe and, every eight internal cycles, the noise shaper tick. The word clock edges are still compared against this counter. If an edge is off by no more than two internal cycles, it is tolerated and the grid is left alone. A larger offset reloads the counter so that the strobe realigns with the word clock.

Input words are taken into a first register on the rising word clock edge. The load strobe then moves them into a second register in the system clock domain. A single corrupt period does not break lock, which makes the block tolerant of word clock jitter and glitches. A rate change, or a word clock that stops, drops lock.

Top module: `wclk_rate_tracker`

## Requirements
- R1: With `div_sel` = 1 every `clk_in` cycle is an internal cycle. With `div_sel` = 0 only every second one is. While locked, `ns_tick` therefore repeats every 8 `clk_in` cycles (`div_sel` = 1) or every 16 (`div_sel` = 0).
- R2: While `locked` is 1, `os_factor` equals the number of internal cycles in one word clock period divided by 8, and it lies between 3 and 24.
- R3: `locked` rises once two consecutive word clock periods measure the same valid factor.
- R4: A period that is not a multiple of 8 internal cycles, or that gives n below 3 or above 24, never leads to lock. While locked, two consecutive bad periods drop lock. One bad period on its own keeps `locked` and `os_factor` unchanged.
- R5: If no rising word clock edge arrives for more than 8·24+8 internal cycles, `locked` falls without waiting for another edge.
- R6: `load_stb` is a one-cycle pulse. It occurs only while locked, once every 8·n internal cycles in steady state, and never while unlocked.
- R7: With `div_sel` = 1 and a steady word clock, `load_stb` is high in the cycle that follows the third rising `clk_in` edge after the word clock rises.
- R8: A word clock edge that arrives up to 2 internal cycles off the strobe grid leaves the grid where it is. An edge that arrives further off reloads the counter, which restores the R7 timing.
- R9: While locked, exactly n `ns_tick` pulses fall within each strobe frame, and one of them coincides with `load_stb`.
- R10: `din` is captured on the rising word clock edge. `sample_out` takes the captured word in the cycle after `load_stb` and changes at no other time, so `din` has no effect while unlocked.
- R11: While `rst_n` is low, `locked`, `load_stb`, `ns_tick`, `os_factor` and `sample_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | External system clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_sel | input | 1 | 1: internal cycle = clk_in; 0: internal cycle = clk_in / 2 |
| wclk | input | 1 | Received word clock, asynchronous |
| din | input | DATA_W | Input sample word |
| ns_tick | output | 1 | Noise shaper tick, one per 8 internal cycles |
| load_stb | output | 1 | Sample-load strobe, one per word period while locked |
| sample_out | output | DATA_W | Sample word moved into the system clock domain |
| os_factor | output | FAC_W | Measured oversampling factor n |
| locked | output | 1 | Rate measurement is stable |

## Verification
A wrong period count or a wrong candidate comparison shows up within three word periods: `locked` is wrong or `os_factor` is off. A corrupted frame counter appears at once, in the spacing between `load_stb` pulses and in the number of ticks per frame. Wrong phase decisions move the delay from the word clock edge to the strobe. A bad tolerance window leaves that delay at the shifted value, or returns it, one word period after a deliberate jump. Faults in the data path show within one frame after a strobe, as a stale or changed `sample_out`.

// File: rtl/wrt_pkg.sv
package wrt_pkg;
    // internal cycles between shaper ticks; the frame is a multiple of it
    localparam int unsigned TICK_CYCLES = 8;

    typedef enum logic [1:0] {
        PH_FREE   = 2'd0,   // unlocked: count freely
        PH_KEEP   = 2'd1,   // locked: wrap at the frame end
        PH_RELOAD = 2'd2    // restart the frame at zero
    } phase_act_e;
endpackage

// File: rtl/wrt_clk_enable.sv
module wrt_clk_enable (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic div_sel_i,
    output logic ce_o
);
    typedef struct packed {
        logic half;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.half = ~st_q.half;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ce_o = div_sel_i | st_q.half;
endmodule

// File: rtl/wrt_edge_sync.sv
module wrt_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ce_i,
    input  logic async_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES:0] sh;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ce_i) st_d.sh = {st_q.sh[STAGES-1:0], async_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rise_o = ce_i & st_q.sh[STAGES-1] & ~st_q.sh[STAGES];
endmodule

// File: rtl/wrt_period_meter.sv
module wrt_period_meter #(
    parameter int unsigned N_MIN = 3,
    parameter int unsigned N_MAX = 24,
    localparam int unsigned CNT_W = $clog2(8 * N_MAX + 10),
    localparam int unsigned FAC_W = CNT_W - 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ce_i,
    input  logic             rise_i,
    output logic [FAC_W-1:0] factor_o,
    output logic             lock_o
);
    localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(8 * N_MAX + 8);
    localparam logic [FAC_W-1:0] F_MIN   = FAC_W'(N_MIN);
    localparam logic [FAC_W-1:0] F_MAX   = FAC_W'(N_MAX);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic [FAC_W-1:0] cand;
        logic             cand_ok;
        logic [FAC_W-1:0] factor;
        logic             lock;
        logic             miss;
    } st_t;

    st_t              st_d, st_q;
    logic [CNT_W-1:0] meas;
    logic [FAC_W-1:0] meas_n;
    logic             meas_ok;

    always_comb begin
        st_d    = st_q;
        meas    = st_q.cnt + CNT_W'(1);
        meas_n  = meas[CNT_W-1:3];
        meas_ok = (meas[2:0] == 3'd0) && (meas_n >= F_MIN) && (meas_n <= F_MAX);
        if (ce_i) begin
            if (rise_i) begin
                st_d.cnt   = '0;
                st_d.armed = 1'b1;
                if (st_q.armed) begin
                    if (!st_q.lock) begin
                        if (meas_ok && st_q.cand_ok && meas_n == st_q.cand) begin
                            st_d.lock   = 1'b1;
                            st_d.factor = meas_n;
                        end
                        st_d.cand    = meas_n;
                        st_d.cand_ok = meas_ok;
                    end else if (meas_ok && meas_n == st_q.factor) begin
                        st_d.miss = 1'b0;
                    end else if (st_q.miss) begin
                        st_d.lock    = 1'b0;
                        st_d.miss    = 1'b0;
                        st_d.cand    = meas_n;
                        st_d.cand_ok = meas_ok;
                    end else begin
                        st_d.miss = 1'b1;
                    end
                end
            end else if (st_q.cnt == CNT_LIM) begin
                // word clock absent for too long: give up at once
                st_d.lock    = 1'b0;
                st_d.miss    = 1'b0;
                st_d.cand_ok = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign factor_o = st_q.factor;
    assign lock_o   = st_q.lock;
endmodule

// File: rtl/wrt_phase_tracker.sv
module wrt_phase_tracker
    import wrt_pkg::*;
#(
    parameter int unsigned N_MAX     = 24,
    parameter int unsigned PHASE_TOL = 2,
    localparam int unsigned CNT_W = $clog2(8 * N_MAX + 10),
    localparam int unsigned FAC_W = CNT_W - 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ce_i,
    input  logic             rise_i,
    input  logic             lock_i,
    input  logic [FAC_W-1:0] factor_i,
    output logic             load_o,
    output logic             tick_o
);
    localparam logic [CNT_W-1:0] TOL = CNT_W'(PHASE_TOL);

    typedef struct packed {
        logic [CNT_W-1:0] fc;
        logic             load;
        logic             tick;
    } st_t;

    st_t              st_d, st_q;
    logic [CNT_W-1:0] last, early, late, nxt;
    phase_act_e       act;

    always_comb begin
        st_d      = st_q;
        st_d.load = 1'b0;
        st_d.tick = 1'b0;
        last  = {factor_i, 3'b000} - CNT_W'(1);
        early = (st_q.fc <= last) ? (last - st_q.fc) : '0;
        late  = st_q.fc + CNT_W'(1);
        if (!lock_i)
            act = rise_i ? PH_RELOAD : PH_FREE;
        else if (rise_i && early > TOL && late > TOL)
            act = PH_RELOAD;
        else
            act = PH_KEEP;
        case (act)
            PH_FREE: nxt = st_q.fc + CNT_W'(1);
            PH_KEEP: nxt = (st_q.fc >= last) ? '0 : st_q.fc + CNT_W'(1);
            default: nxt = '0;
        endcase
        if (ce_i) begin
            st_d.fc   = nxt;
            st_d.tick = (nxt[2:0] == 3'd0);
            st_d.load = lock_i && (nxt == '0);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign load_o = st_q.load;
    assign tick_o = st_q.tick;
endmodule

// File: rtl/wclk_rate_tracker.sv
module wclk_rate_tracker #(
    parameter int unsigned DATA_W    = 24,
    parameter int unsigned N_MIN     = 3,
    parameter int unsigned N_MAX     = 24,
    parameter int unsigned PHASE_TOL = 2,
    localparam int unsigned CNT_W = $clog2(8 * N_MAX + 10),
    localparam int unsigned FAC_W = CNT_W - 3
) (
    input  logic              clk_in,
    input  logic              rst_n,
    input  logic              div_sel,
    input  logic              wclk,
    input  logic [DATA_W-1:0] din,
    output logic              ns_tick,
    output logic              load_stb,
    output logic [DATA_W-1:0] sample_out,
    output logic [FAC_W-1:0]  os_factor,
    output logic              locked
);
    logic ce, rise;

    wrt_clk_enable u_ce (
        .clk_i(clk_in), .rst_ni(rst_n), .div_sel_i(div_sel), .ce_o(ce)
    );

    wrt_edge_sync #(.STAGES(2)) u_sync (
        .clk_i(clk_in), .rst_ni(rst_n), .ce_i(ce), .async_i(wclk), .rise_o(rise)
    );

    wrt_period_meter #(.N_MIN(N_MIN), .N_MAX(N_MAX)) u_meter (
        .clk_i(clk_in), .rst_ni(rst_n), .ce_i(ce), .rise_i(rise),
        .factor_o(os_factor), .lock_o(locked)
    );

    wrt_phase_tracker #(.N_MAX(N_MAX), .PHASE_TOL(PHASE_TOL)) u_track (
        .clk_i(clk_in), .rst_ni(rst_n), .ce_i(ce), .rise_i(rise),
        .lock_i(locked), .factor_i(os_factor),
        .load_o(load_stb), .tick_o(ns_tick)
    );

    // first stage: word clock domain
    logic [DATA_W-1:0] cap_q;
    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= din;
    end

    // second stage: system clock domain, moved on the load strobe
    typedef struct packed {
        logic [DATA_W-1:0] smp;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_stb) st_d.smp = cap_q;
    end

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sample_out = st_q.smp;
endmodule

module wrt_checker #(
    parameter int unsigned DATA_W = 24,
    parameter int unsigned FAC_W  = 5,
    parameter int unsigned N_MIN  = 3,
    parameter int unsigned N_MAX  = 24
) (
    input logic              clk_in,
    input logic              rst_n,
    input logic              locked,
    input logic              load_stb,
    input logic              ns_tick,
    input logic [FAC_W-1:0]  os_factor,
    input logic [DATA_W-1:0] sample_out
);
    AST_LOAD_NEEDS_LOCK: assert property (@(posedge clk_in) disable iff (!rst_n)
        load_stb |-> $past(locked));                                        // R6
    AST_LOAD_ONE_CYCLE: assert property (@(posedge clk_in) disable iff (!rst_n)
        load_stb |=> !load_stb);                                            // R6
    AST_FACTOR_IN_RANGE: assert property (@(posedge clk_in) disable iff (!rst_n)
        locked |-> (os_factor >= FAC_W'(N_MIN) && os_factor <= FAC_W'(N_MAX))); // R2
    AST_SAMPLE_MOVES_ON_LOAD: assert property (@(posedge clk_in) disable iff (!rst_n)
        !$stable(sample_out) |-> $past(load_stb));                          // R10
    AST_TICK_ONE_CYCLE: assert property (@(posedge clk_in) disable iff (!rst_n)
        (locked && ns_tick) |=> !ns_tick);                                  // R9
endmodule

bind wclk_rate_tracker wrt_checker #(
    .DATA_W(DATA_W), .FAC_W(FAC_W), .N_MIN(N_MIN), .N_MAX(N_MAX)
) u_chk (
    .clk_in(clk_in), .rst_n(rst_n), .locked(locked), .load_stb(load_stb),
    .ns_tick(ns_tick), .os_factor(os_factor), .sample_out(sample_out)
);

// File: tb/wclk_rate_tracker_bench.sv
module wclk_rate_tracker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;
    // {div_sel, word period in clk_in cycles, expected n, expected lock}
    localparam int VEC [NV][4] = '{
        '{1,  24,  3, 1}, '{1,  64,  8, 1}, '{1, 192, 24, 1}, '{0,  96,  6, 1},
        '{0, 384, 24, 1}, '{1, 100,  0, 0}, '{1,  16,  2, 0}, '{1, 200, 25, 0},
        '{0,  48,  3, 1}, '{1,  96, 12, 1}
    };

    logic        clk = 0, rst_n = 0, div_sel = 1, wclk = 0;
    logic [23:0] din = '0;
    logic        ns_tick, load_stb, locked;
    logic [23:0] sample_out;
    logic [4:0]  os_factor;

    wclk_rate_tracker u_wclk_rate_tracker (
        .clk_in(clk), .rst_n(rst_n), .div_sel(div_sel), .wclk(wclk), .din(din),
        .ns_tick(ns_tick), .load_stb(load_stb), .sample_out(sample_out),
        .os_factor(os_factor), .locked(locked)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int wper = 64, extra = 0;
    bit stop = 1;

    // word clock generator, edges 2 time units after a clk_in rising edge
    initial begin
        forever begin
            if (stop) @(posedge clk);
            else begin
                int lo, hi;
                lo = wper / 2;
                repeat (lo) @(posedge clk);
                #2 wclk = 1;
                hi = wper - lo + extra;
                extra = 0;
                repeat (hi) @(posedge clk);
                #2 wclk = 0;
            end
        end
    end

    // observers, sampled on the falling edge
    int since_w = 0, lat_last = -1, cyc_ld = 0, cyc_tk = 0;
    int load_iv = 0, tick_iv = 0, load_cnt = 0, tick_acc = 0, frame_ticks = 0;
    logic wclk_prev = 0;
    always @(negedge clk) begin
        since_w = (wclk && !wclk_prev) ? 0 : since_w + 1;
        wclk_prev = wclk;
        cyc_ld = cyc_ld + 1;
        cyc_tk = cyc_tk + 1;
        if (load_stb) begin
            load_iv = cyc_ld; cyc_ld = 0; load_cnt = load_cnt + 1;
            lat_last = since_w; frame_ticks = tick_acc; tick_acc = 0;
        end
        if (ns_tick) begin
            tick_iv = cyc_tk; cyc_tk = 0; tick_acc = tick_acc + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk = n_chk + 1; n_fail = n_fail + 1;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int base;
        logic [23:0] held;
        // R11: reset state
        wait_clk(4);
        check(locked == 0, "R11 locked", int'(locked), 0);
        check(load_stb == 0, "R11 load_stb", int'(load_stb), 0);
        check(ns_tick == 0, "R11 ns_tick", int'(ns_tick), 0);
        check(os_factor == 0, "R11 os_factor", int'(os_factor), 0);
        check(sample_out == 0, "R11 sample_out", int'(sample_out), 0);
        rst_n = 1;
        stop = 0;

        for (int i = 0; i < NV; i++) begin
            div_sel = VEC[i][0][0];
            wper = VEC[i][1];
            wait_clk(6 * wper + 100);
            base = load_cnt;
            wait_clk(3 * wper);
            check(int'(locked) == VEC[i][3], (VEC[i][3] != 0) ? "R3 lock" : "R4 no lock",
                  int'(locked), VEC[i][3]);
            if (VEC[i][3] != 0) begin
                check(int'(os_factor) == VEC[i][2], "R2 factor", int'(os_factor), VEC[i][2]);
                check(load_iv == wper, "R6 strobe spacing", load_iv, wper);
                check(tick_iv == (div_sel ? 8 : 16), "R1 tick spacing", tick_iv, div_sel ? 8 : 16);
                check(frame_ticks == VEC[i][2], "R9 ticks per frame", frame_ticks, VEC[i][2]);
            end else begin
                check(load_cnt == base, "R6 no strobe unlocked", load_cnt - base, 0);
            end
        end

        // R10 data transfer and R7 latency at n = 8
        div_sel = 1; wper = 64;
        wait_clk(700);
        din = 24'h5AC317;
        wait_clk(4 * 64);
        check(sample_out == 24'h5AC317, "R10 word moved", int'(sample_out), 24'h5AC317);
        din = 24'hA50FF0;
        wait_clk(4 * 64);
        check(sample_out == 24'hA50FF0, "R10 word moved", int'(sample_out), 24'hA50FF0);
        check(lat_last == 3, "R7 strobe latency", lat_last, 3);

        // R8 small shift tolerated, single bad period keeps lock (R4)
        extra = 2;
        wait_clk(5 * 64);
        check(locked == 1, "R4 one bad period", int'(locked), 1);
        check(os_factor == 8, "R4 factor held", int'(os_factor), 8);
        check(lat_last == 1, "R8 grid kept", lat_last, 1);
        check(load_iv == 64, "R8 spacing kept", load_iv, 64);
        // R8 large shift realigns
        extra = 5;
        wait_clk(5 * 64);
        check(lat_last == 3, "R8 grid reloaded", lat_last, 3);
        check(locked == 1, "R8 lock kept", int'(locked), 1);
        check(load_iv == 64, "R8 spacing", load_iv, 64);

        // R10 din ignored while unlocked
        wper = 100;
        wait_clk(800);
        check(locked == 0, "R4 two bad periods", int'(locked), 0);
        held = sample_out;
        base = load_cnt;
        din = 24'h0F1E2D;
        wait_clk(500);
        check(sample_out == held, "R10 held unlocked", int'(sample_out), int'(held));
        check(load_cnt == base, "R6 no strobe unlocked", load_cnt - base, 0);

        // R5 word clock stops
        wper = 64;
        wait_clk(800);
        check(locked == 1, "R3 relock", int'(locked), 1);
        stop = 1;
        wait_clk(400);
        check(locked == 0, "R5 timeout", int'(locked), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule